// File: doc/BRIEF.md
# Dual Interval Timer (One-Shot and Periodic)

This block holds two 32-bit down-counting timers that sit behind a small memory-mapped register window. One timer is a one-shot: it fires once and then disarms itself. The other is periodic: it fires and then reloads its interval. Each timer has two registers. The interval register holds the value most recently programmed. The remaining register shows how many ticks are left before the next expiry. Counting advances only on clock cycles where the external tick-enable input is high. Each expiry produces a single-cycle pulse on that timer's own output.

Software programs a timer by writing its interval register. A write of zero disarms the timer. A nonzero write N cancels any pending expiry and restarts the timer, so that it expires N ticks after the write. Registers are 32-bit big-endian words and accept only full-word accesses. Any other access size to a timer register returns an error response and changes nothing.

Each timer is a two-state machine with states IDLE and ARMED. Its transitions are:
- arm: IDLE to ARMED, on a nonzero write.
- rearm: ARMED to ARMED, on a nonzero write.
- disarm: ARMED to IDLE, on a zero write.
- expire_oneshot: ARMED to IDLE, when the one-shot timer expires.
- expire_reload: ARMED to ARMED, when the periodic timer expires.

Every access gets a response one cycle after the request.

Top module: `tick_timer_pair`

## Requirements
- R1: After reset, all four registers read 0, both fire outputs are low and resp_valid is low.
- R2: Bus byte lane k (bits 8k+7:8k of req_wdata and resp_rdata) carries the byte at address offset k. The byte at offset 0 is the most significant byte of the 32-bit value.
- R3: An access to any of the four timer registers (offsets 0x20, 0x24, 0x28, 0x2C) with req_size other than 4 produces resp_err=1 and resp_rdata=0 in the response cycle. It leaves every timer register unchanged.
- R4: A full-word write of a nonzero N to an interval register (0x20 one-shot, 0x28 periodic) restarts that timer. Its remaining register then reads N. The timer's fire output pulses in the cycle after the N-th tick-enabled cycle that follows the write.
- R5: The remaining count decreases by one only on cycles where tick_en is high. Idle cycles leave it unchanged.
- R6: A write of 0 to an interval register disarms that timer. Both of its registers then read 0, and it does not fire.
- R7: When the one-shot timer expires, it fires once. Afterwards both its interval (0x20) and remaining (0x24) registers read 0.
- R8: When the periodic timer expires, it fires and reloads. It fires again every N ticks, and its interval register (0x28) keeps reading N.
- R9: A read of an interval register returns the last value written, except for an expired one-shot timer.
- R10: If an interval write lands in the same cycle as that timer's expiry, the write wins and no fire pulse is produced.
- R11: Writes to the remaining registers (0x24, 0x2C) have no effect.
- R12: The one-shot fire pulse lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Count-enable tick |
| req_valid | input | 1 | Access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 6 | Byte offset within the window |
| req_size | input | 3 | Access size in bytes |
| req_wdata | input | 32 | Write data, byte lane k = offset k |
| resp_valid | output | 1 | Response valid, one cycle after request |
| resp_err | output | 1 | Rejected access |
| resp_rdata | output | 32 | Read data, byte lane k = offset k |
| oneshot_fire | output | 1 | One-shot expiry pulse |
| periodic_fire | output | 1 | Periodic expiry pulse |

## Verification
The hardest case to reach from the ports is an interval write that arrives in exactly the cycle when the timer's remaining count is 1 and tick_en is high. The stimulus first walks the timer down one tick at a time, reading the remaining register after each tick. It then issues the write in the same cycle as the final tick. Sweeps over intervals 1 through 6 on both timers cover reload on every expiry (including period 1, where the periodic timer fires on consecutive ticks) and the one-shot self-clear.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_ARMED = 1'b1
    } tmr_state_e;

    localparam int WORD_BYTES = 4;
    localparam logic [5:0] OFF_OS_INTV  = 6'h20;
    localparam logic [5:0] OFF_OS_LEFT  = 6'h24;
    localparam logic [5:0] OFF_PER_INTV = 6'h28;
    localparam logic [5:0] OFF_PER_LEFT = 6'h2C;

    function automatic logic [31:0] lane_swap(input logic [31:0] v);
        return {v[7:0], v[15:8], v[23:16], v[31:24]};
    endfunction
endpackage

// File: rtl/tmr_unit.sv
module tmr_unit
    import tmr_pkg::*;
#(
    parameter int  W        = 32,
    parameter bit  PERIODIC = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_en,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] interval,
    output logic [W-1:0] remain,
    output logic         fire
);
    localparam logic [W-1:0] ONE = W'(1);

    tmr_state_e state_q, state_d;
    logic       expire;

    assign expire = (state_q == ST_ARMED) && tick_en && (remain == ONE);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (load && load_val != '0) state_d = ST_ARMED;        // arm
            end
            ST_ARMED: begin
                if (load)                   state_d = (load_val == '0) ? ST_IDLE : ST_ARMED; // disarm / rearm
                else if (expire && !PERIODIC) state_d = ST_IDLE;       // expire_oneshot
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            interval <= '0;
            remain   <= '0;
            fire     <= 1'b0;
        end else begin
            fire <= expire && !load;
            if (load) begin
                interval <= load_val;
                remain   <= load_val;
            end else if (expire) begin
                if (PERIODIC) begin
                    remain <= interval;                                 // expire_reload
                end else begin
                    interval <= '0;
                    remain   <= '0;
                end
            end else if (state_q == ST_ARMED && tick_en) begin
                remain <= remain - ONE;
            end
        end
    end
endmodule

// File: rtl/tmr_regif.sv
module tmr_regif
    import tmr_pkg::*;
#(
    parameter int AW = 6,
    parameter int W  = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [2:0]    req_size,
    input  logic [W-1:0]  req_wdata,
    input  logic [W-1:0]  os_intv,
    input  logic [W-1:0]  os_left,
    input  logic [W-1:0]  per_intv,
    input  logic [W-1:0]  per_left,
    output logic [1:0]    load,
    output logic [W-1:0]  load_val,
    output logic          resp_valid,
    output logic          resp_err,
    output logic [W-1:0]  resp_rdata
);
    logic         hit;
    logic         size_ok;
    logic [W-1:0] rd_val;
    logic [5:0]   off;

    assign off     = 6'(req_addr);
    assign size_ok = (req_size == 3'(WORD_BYTES));
    assign load_val = lane_swap(req_wdata);

    always_comb begin
        hit    = 1'b1;
        rd_val = '0;
        unique case (off)
            OFF_OS_INTV:  rd_val = os_intv;
            OFF_OS_LEFT:  rd_val = os_left;
            OFF_PER_INTV: rd_val = per_intv;
            OFF_PER_LEFT: rd_val = per_left;
            default:      hit    = 1'b0;
        endcase
    end

    assign load[0] = req_valid && req_write && size_ok && (off == OFF_OS_INTV);
    assign load[1] = req_valid && req_write && size_ok && (off == OFF_PER_INTV);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_valid <= 1'b0;
            resp_err   <= 1'b0;
            resp_rdata <= '0;
        end else begin
            resp_valid <= req_valid;
            resp_err   <= req_valid && hit && !size_ok;
            resp_rdata <= (req_valid && !req_write && hit && size_ok) ? lane_swap(rd_val) : '0;
        end
    end
endmodule

// File: rtl/tick_timer_pair.sv
module tick_timer_pair
    import tmr_pkg::*;
#(
    parameter int AW = 6,
    parameter int W  = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_en,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [2:0]    req_size,
    input  logic [W-1:0]  req_wdata,
    output logic          resp_valid,
    output logic          resp_err,
    output logic [W-1:0]  resp_rdata,
    output logic          oneshot_fire,
    output logic          periodic_fire
);
    localparam int NT = 2;

    logic [NT-1:0]  load;
    logic [W-1:0]   load_val;
    logic [W-1:0]   intv [NT];
    logic [W-1:0]   left [NT];
    logic [NT-1:0]  fire;

    tmr_regif #(.AW(AW), .W(W)) u_regif (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_addr   (req_addr),
        .req_size   (req_size),
        .req_wdata  (req_wdata),
        .os_intv    (intv[0]),
        .os_left    (left[0]),
        .per_intv   (intv[1]),
        .per_left   (left[1]),
        .load       (load),
        .load_val   (load_val),
        .resp_valid (resp_valid),
        .resp_err   (resp_err),
        .resp_rdata (resp_rdata)
    );

    for (genvar gi = 0; gi < NT; gi++) begin : g_tmr
        tmr_unit #(.W(W), .PERIODIC(gi == 1)) u_unit (
            .clk      (clk),
            .rst_n    (rst_n),
            .tick_en  (tick_en),
            .load     (load[gi]),
            .load_val (load_val),
            .interval (intv[gi]),
            .remain   (left[gi]),
            .fire     (fire[gi])
        );
    end

    assign oneshot_fire  = fire[0];
    assign periodic_fire = fire[1];
endmodule

// File: rtl/tmr_chk.sv
module tmr_chk #(
    parameter int AW = 6,
    parameter int W  = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          tick_en,
    input logic          req_valid,
    input logic          req_write,
    input logic [AW-1:0] req_addr,
    input logic [2:0]    req_size,
    input logic          resp_valid,
    input logic          resp_err,
    input logic [W-1:0]  resp_rdata,
    input logic          oneshot_fire,
    input logic          periodic_fire
);
    // R5: a fire pulse must follow a tick-enabled cycle
    a_r5_os_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
        oneshot_fire |-> $past(tick_en));
    a_r5_per_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
        periodic_fire |-> $past(tick_en));

    // R12: one-shot pulse is a single cycle
    a_r12_os_single: assert property (@(posedge clk) disable iff (!rst_n)
        oneshot_fire |=> !oneshot_fire);

    // R3: short access to a timer register is rejected with zero data
    a_r3_size_err: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_size != 3'd4 && 6'(req_addr) == 6'h20) |=> (resp_err && resp_rdata == '0));

    // R10: interval write in the same cycle suppresses the pulse
    a_r10_os_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && req_size == 3'd4 && 6'(req_addr) == 6'h20) |=> !oneshot_fire);
    a_r10_per_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && req_size == 3'd4 && 6'(req_addr) == 6'h28) |=> !periodic_fire);

    // R3: error only appears on a response
    a_r3_err_in_resp: assert property (@(posedge clk) disable iff (!rst_n)
        resp_err |-> resp_valid);
endmodule

bind tick_timer_pair tmr_chk #(.AW(AW), .W(W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .tick_en       (tick_en),
    .req_valid     (req_valid),
    .req_write     (req_write),
    .req_addr      (req_addr),
    .req_size      (req_size),
    .resp_valid    (resp_valid),
    .resp_err      (resp_err),
    .resp_rdata    (resp_rdata),
    .oneshot_fire  (oneshot_fire),
    .periodic_fire (periodic_fire)
);

// File: tb/tick_timer_pair_test.sv
module tick_timer_pair_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [5:0]  req_addr = '0;
    logic [2:0]  req_size = 3'd4;
    logic [31:0] req_wdata = '0;
    logic        resp_valid, resp_err, oneshot_fire, periodic_fire;
    logic [31:0] resp_rdata;

    int checks = 0;
    int errors = 0;
    logic [31:0] rd;
    logic        er;
    logic        f_os, f_per;
    bit          done = 0;

    always #2 clk = ~clk;

    tick_timer_pair uut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_size(req_size), .req_wdata(req_wdata),
        .resp_valid(resp_valid), .resp_err(resp_err), .resp_rdata(resp_rdata),
        .oneshot_fire(oneshot_fire), .periodic_fire(periodic_fire)
    );

    function automatic logic [31:0] be(input logic [31:0] v);
        return {v[7:0], v[15:8], v[23:16], v[31:24]};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one bus cycle; response and fire outputs captured at the next negedge
    task automatic access(input bit wr, input logic [5:0] a, input logic [31:0] value,
                          input logic [2:0] sz, input bit tk);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_size = sz;
        req_wdata = be(value); tick_en = tk;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0; tick_en = 1'b0;
        rd = be(resp_rdata); er = resp_err;
        f_os = oneshot_fire; f_per = periodic_fire;
    endtask

    task automatic rreg(input logic [5:0] a);
        access(1'b0, a, 32'h0, 3'd4, 1'b0);
    endtask

    task automatic tick1();
        @(negedge clk);
        tick_en = 1'b1;
        @(negedge clk);
        tick_en = 1'b0;
        f_os = oneshot_fire; f_per = periodic_fire;
    endtask

    initial begin
        #200000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 os_fire", {31'b0, oneshot_fire}, 0);
        chk("R1 per_fire", {31'b0, periodic_fire}, 0);
        chk("R1 resp_valid", {31'b0, resp_valid}, 0);
        rst_n = 1'b1;
        rreg(6'h20); chk("R1 os_intv", rd, 0);
        rreg(6'h24); chk("R1 os_left", rd, 0);
        rreg(6'h28); chk("R1 per_intv", rd, 0);
        rreg(6'h2C); chk("R1 per_left", rd, 0);

        // R2 byte order: raw lanes 0x04030201 means value 0x01020304
        @(negedge clk);
        req_valid = 1; req_write = 1; req_addr = 6'h28; req_size = 3'd4; req_wdata = 32'h04030201;
        @(negedge clk);
        req_valid = 0; req_write = 0;
        access(1'b0, 6'h28, 0, 3'd4, 1'b0);
        chk("R2 raw lanes", resp_rdata, 32'h04030201);
        chk("R2 value", rd, 32'h01020304);

        // R3 size errors leave state unchanged
        for (int s = 0; s < 8; s++) begin
            if (s == 4) continue;
            access(1'b1, 6'h28, 32'h55, 3'(s), 1'b0);
            chk("R3 err write", {31'b0, er}, 1);
            access(1'b0, 6'h2C, 0, 3'(s), 1'b0);
            chk("R3 err read", {31'b0, er}, 1);
            chk("R3 err rdata", be(rd), 0);
        end
        rreg(6'h28); chk("R3 intv unchanged", rd, 32'h01020304);
        rreg(6'h2C); chk("R3 left unchanged", rd, 32'h01020304);

        // R6 disarm both
        access(1'b1, 6'h28, 0, 3'd4, 1'b0);
        rreg(6'h2C); chk("R6 per_left", rd, 0);
        rreg(6'h28); chk("R6 per_intv", rd, 0);
        for (int k = 0; k < 4; k++) begin
            tick1(); chk("R6 no fire", {31'b0, f_per}, 0);
        end

        // R4/R5/R7/R9/R12 one-shot sweep
        for (int n = 1; n <= 6; n++) begin
            access(1'b1, 6'h20, 32'(n), 3'd4, 1'b0);
            rreg(6'h24); chk("R4 os_left load", rd, 32'(n));
            rreg(6'h20); chk("R9 os_intv", rd, 32'(n));
            repeat (3) @(negedge clk);
            rreg(6'h24); chk("R5 idle hold", rd, 32'(n));
            for (int k = 1; k <= n; k++) begin
                tick1();
                chk("R4 os fire timing", {31'b0, f_os}, (k == n) ? 32'd1 : 32'd0);
                @(negedge clk);
                chk("R12 os single", {31'b0, oneshot_fire}, 0);
                if (k < n) begin
                    rreg(6'h24); chk("R5 os_left", rd, 32'(n - k));
                end
            end
            rreg(6'h20); chk("R7 os_intv cleared", rd, 0);
            rreg(6'h24); chk("R7 os_left cleared", rd, 0);
            tick1(); chk("R7 no refire", {31'b0, f_os}, 0);
        end

        // R8 periodic sweep
        for (int n = 1; n <= 6; n++) begin
            access(1'b1, 6'h28, 32'(n), 3'd4, 1'b0);
            for (int k = 1; k <= 3 * n; k++) begin
                tick1();
                chk("R8 per fire", {31'b0, f_per}, (k % n == 0) ? 32'd1 : 32'd0);
                rreg(6'h2C); chk("R8 per_left", rd, 32'(n - (k % n)));
            end
            rreg(6'h28); chk("R8 per_intv kept", rd, 32'(n));
        end

        // R11 remaining registers ignore writes
        access(1'b1, 6'h28, 32'd9, 3'd4, 1'b0);
        access(1'b1, 6'h2C, 32'd3, 3'd4, 1'b0);
        rreg(6'h2C); chk("R11 per_left", rd, 9);
        access(1'b1, 6'h24, 32'd3, 3'd4, 1'b0);
        rreg(6'h24); chk("R11 os_left", rd, 0);
        rreg(6'h20); chk("R11 os_intv", rd, 0);

        // R10 write colliding with expiry (one-shot)
        access(1'b1, 6'h20, 32'd3, 3'd4, 1'b0);
        tick1(); tick1();
        rreg(6'h24); chk("R10 os pre", rd, 1);
        access(1'b1, 6'h20, 32'd5, 3'd4, 1'b1);
        chk("R10 os suppressed", {31'b0, f_os}, 0);
        rreg(6'h24); chk("R10 os restarted", rd, 5);
        rreg(6'h20); chk("R10 os intv", rd, 5);

        // R10 periodic collision
        access(1'b1, 6'h28, 32'd2, 3'd4, 1'b0);
        tick1();
        access(1'b1, 6'h28, 32'd4, 3'd4, 1'b1);
        chk("R10 per suppressed", {31'b0, f_per}, 0);
        rreg(6'h2C); chk("R10 per restarted", rd, 4);

        // R4 rewrite mid-count restarts
        tick1();
        access(1'b1, 6'h28, 32'd2, 3'd4, 1'b0);
        tick1(); chk("R4 restart no fire", {31'b0, f_per}, 0);
        tick1(); chk("R4 restart fire", {31'b0, f_per}, 1);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule